// File: doc/BRIEF.md
# Chip-Select Framed Serial Byte Port

This block terminates a half-duplex serial control port built from an active-low select line, a data clock and one shared data line, and exchanges single bytes with a command layer. Each low interval of the select line is one byte frame. The port counts the rising data-clock edges inside the frame and sorts the frame by that count. A frame that is too short is dropped without trace. A frame of normal length hands the last eight sampled bits to the command layer. A frame that is far too long raises a hardware reset request.

When the command layer holds a read byte pending, the port drives that byte out on the data line, most significant bit first. It changes the output bit on falling clock edges, so the host can sample it on rising edges. The port also watches for a second condition: the select line held low while the clock stays still across several frame-sync pulses. When that happens it raises an alternate-mode request, which stays up until the select line goes high again.

All pins are sampled on a fast system clock through two-flop synchronizers. Every event is taken from those synchronized copies.

Top module: `cs_byte_port`

## Requirements
- R1: After reset, `rx_valid`, `hw_reset_req`, `tx_taken`, `alt_mode_req` and `dio_oe` are all 0.
- R2: A frame with exactly 8 rising data-clock edges produces one `rx_valid` pulse. `rx_byte` holds the bits sampled on those edges, the first-sampled bit in bit 7.
- R3: A frame with fewer than 8 rising edges produces no `rx_valid` pulse, no `hw_reset_req` pulse and no `tx_taken` pulse. A pending read byte stays pending and is driven again, from its bit 7, in the next frame.
- R4: A frame with 9 to 15 rising edges delivers in `rx_byte` only the bits sampled on its last 8 edges, the earliest of them in bit 7.
- R5: A frame with 16 or more rising edges produces one `hw_reset_req` pulse and no `rx_valid` or `tx_taken` pulse.
- R6: While the select line is high, data-clock activity of any kind, including toggling or resting at either level, changes no output. It also does not alter the byte received in the next frame.
- R7: If `tx_valid` is 1 when the select line falls, `dio_oe` rises and `dio_out` shows bit 7 of `tx_byte` before any clock edge. After each falling clock edge that follows a rising edge in the frame, the next lower bit is shown. A frame of 8 to 15 edges then ends with one `tx_taken` pulse.
- R8: `dio_oe` is 0 whenever the select line is high, and it stays 0 for a whole frame that began with `tx_valid` at 0.
- R9: If the select line stays low with no rising data-clock edge while `FS_PERIODS` (default 2) rising frame-sync edges occur, `alt_mode_req` goes to 1. It returns to 0 once the select line goes high.
- R10: If a rising data-clock edge occurs during the low interval, `alt_mode_req` stays 0 for the rest of that interval, whatever the frame-sync activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the data clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame select, low during a byte frame |
| sclk | input | 1 | Serial data clock |
| fsync | input | 1 | Frame-sync pulse train |
| dio_in | input | 1 | Data line as seen at the pad |
| dio_out | output | 1 | Data line drive value |
| dio_oe | output | 1 | Data line output enable |
| tx_byte | input | 8 | Read byte offered by the command layer |
| tx_valid | input | 1 | Read byte pending |
| tx_taken | output | 1 | One-cycle pulse: pending byte was sent in a valid frame |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_byte` updated |
| hw_reset_req | output | 1 | One-cycle pulse: overlong frame seen |
| alt_mode_req | output | 1 | Static-clock select-low condition present |

## Verification
Any pin change becomes visible to the port logic after two synchronizer flops. The registered results (`rx_valid`, `hw_reset_req`, `tx_taken`, `dio_oe` and a shifted `dio_out`) are therefore due on the third system-clock edge after the pin moves. `alt_mode_req` is due on the fourth edge after the qualifying frame-sync rise. The bench holds every serial level for six system clocks, so the host's read of `dio_out` always follows the shift caused by the preceding falling edge. After raising the select line it waits eight clocks before comparing the pulse counts its monitor collected on falling system-clock edges, and it samples `alt_mode_req` at least ten clocks after the relevant frame-sync or select-line change.

// File: rtl/csp_pkg.sv
package csp_pkg;

    localparam int BYTE_W      = 8;
    localparam int LONG_EDGES  = 2 * BYTE_W;
    localparam int CNT_W       = $clog2(LONG_EDGES) + 1;

    typedef enum logic [1:0] {
        FR_SHORT = 2'd0,
        FR_BYTE  = 2'd1,
        FR_LONG  = 2'd2
    } frame_kind_e;

    // synchronized pin view and the events derived from it
    typedef struct packed {
        logic cs_low;
        logic cs_fall;
        logic cs_rise;
        logic clk_rise;
        logic clk_fall;
        logic fs_rise;
        logic din;
    } port_ev_t;

    function automatic frame_kind_e classify(input logic [CNT_W-1:0] edges);
        if (edges >= CNT_W'(LONG_EDGES))
            return FR_LONG;
        else if (edges >= CNT_W'(BYTE_W))
            return FR_BYTE;
        else
            return FR_SHORT;
    endfunction

endpackage

// File: rtl/csp_sync.sv
module csp_sync #(
    parameter int          W      = 4,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_V = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= {STAGES{RST_V}};
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/csp_frame.sv
module csp_frame
    import csp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_low,
    input  logic                cs_fall,
    input  logic                cs_rise,
    input  logic                clk_rise,
    input  logic                din,
    output logic [CNT_W-1:0]    edges,
    output logic [BYTE_W-1:0]   rx_byte,
    output logic                rx_valid,
    output logic                hw_reset_req
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LONG_EDGES);

    logic [BYTE_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            edges        <= '0;
            shreg        <= '0;
            rx_byte      <= '0;
            rx_valid     <= 1'b0;
            hw_reset_req <= 1'b0;
        end else begin
            rx_valid     <= 1'b0;
            hw_reset_req <= 1'b0;
            if (cs_fall) begin
                edges <= '0;
            end else if (cs_low && clk_rise) begin
                shreg <= {shreg[BYTE_W-2:0], din};
                if (edges != CNT_SAT)
                    edges <= edges + 1'b1;
            end
            if (cs_rise) begin
                unique case (classify(edges))
                    FR_BYTE: begin
                        rx_valid <= 1'b1;
                        rx_byte  <= shreg;
                    end
                    FR_LONG:  hw_reset_req <= 1'b1;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/csp_tx.sv
module csp_tx
    import csp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_fall,
    input  logic                cs_rise,
    input  logic                clk_fall,
    input  logic [CNT_W-1:0]    edges,
    input  logic [BYTE_W-1:0]   tx_byte,
    input  logic                tx_valid,
    output logic                dio_out,
    output logic                dio_oe,
    output logic                tx_taken
);
    logic              active;
    logic [BYTE_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            shreg    <= '0;
            tx_taken <= 1'b0;
        end else begin
            tx_taken <= 1'b0;
            if (cs_fall) begin
                active <= tx_valid;
                shreg  <= tx_byte;
            end else if (cs_rise) begin
                if (active && classify(edges) == FR_BYTE)
                    tx_taken <= 1'b1;
                active <= 1'b0;
            end else if (active && clk_fall && edges != '0) begin
                shreg <= {shreg[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign dio_oe  = active;
    assign dio_out = active & shreg[BYTE_W-1];
endmodule

// File: rtl/csp_static.sv
module csp_static #(
    parameter int FS_PERIODS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_low,
    input  logic cs_fall,
    input  logic clk_rise,
    input  logic fs_rise,
    output logic alt_mode_req
);
    localparam int FW = $clog2(FS_PERIODS + 1);
    localparam logic [FW-1:0] FS_TGT = FW'(FS_PERIODS);

    logic [FW-1:0] fs_cnt;
    logic          blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_cnt       <= '0;
            blocked      <= 1'b0;
            alt_mode_req <= 1'b0;
        end else if (cs_fall) begin
            fs_cnt       <= '0;
            blocked      <= clk_rise;
            alt_mode_req <= 1'b0;
        end else if (!cs_low) begin
            fs_cnt       <= '0;
            alt_mode_req <= 1'b0;
        end else if (clk_rise) begin
            blocked      <= 1'b1;
            alt_mode_req <= 1'b0;
        end else begin
            if (fs_rise && !blocked && fs_cnt != FS_TGT)
                fs_cnt <= fs_cnt + 1'b1;
            alt_mode_req <= !blocked && (fs_cnt == FS_TGT);
        end
    end
endmodule

// File: rtl/cs_byte_port.sv
module cs_byte_port
    import csp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FS_PERIODS  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              fsync,
    input  logic              dio_in,
    output logic              dio_out,
    output logic              dio_oe,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_valid,
    output logic              tx_taken,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              hw_reset_req,
    output logic              alt_mode_req
);
    logic [3:0]       pins_s;
    logic             cs_s, sck_s, fs_s, din_s;
    logic             cs_q, sck_q, fs_q;
    port_ev_t         ev;
    logic [CNT_W-1:0] edges;

    csp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_V(4'b1000)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sclk, fsync, dio_in}),
        .q   (pins_s)
    );

    assign {cs_s, sck_s, fs_s, din_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
            fs_q  <= 1'b0;
        end else begin
            cs_q  <= cs_s;
            sck_q <= sck_s;
            fs_q  <= fs_s;
        end
    end

    always_comb begin
        ev.cs_low   = !cs_s;
        ev.cs_fall  = !cs_s &&  cs_q;
        ev.cs_rise  =  cs_s && !cs_q;
        ev.clk_rise =  sck_s && !sck_q;
        ev.clk_fall = !sck_s &&  sck_q;
        ev.fs_rise  =  fs_s && !fs_q;
        ev.din      =  din_s;
    end

    csp_frame u_frame (
        .clk          (clk),
        .rst          (rst),
        .cs_low       (ev.cs_low),
        .cs_fall      (ev.cs_fall),
        .cs_rise      (ev.cs_rise),
        .clk_rise     (ev.clk_rise),
        .din          (ev.din),
        .edges        (edges),
        .rx_byte      (rx_byte),
        .rx_valid     (rx_valid),
        .hw_reset_req (hw_reset_req)
    );

    csp_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .cs_fall  (ev.cs_fall),
        .cs_rise  (ev.cs_rise),
        .clk_fall (ev.clk_fall),
        .edges    (edges),
        .tx_byte  (tx_byte),
        .tx_valid (tx_valid),
        .dio_out  (dio_out),
        .dio_oe   (dio_oe),
        .tx_taken (tx_taken)
    );

    csp_static #(.FS_PERIODS(FS_PERIODS)) u_static (
        .clk          (clk),
        .rst          (rst),
        .cs_low       (ev.cs_low),
        .cs_fall      (ev.cs_fall),
        .clk_rise     (ev.clk_rise),
        .fs_rise      (ev.fs_rise),
        .alt_mode_req (alt_mode_req)
    );
endmodule

// File: rtl/csp_chk.sv
module csp_chk (
    input logic clk,
    input logic rst,
    input logic cs_s,
    input logic dio_oe,
    input logic tx_taken,
    input logic rx_valid,
    input logic hw_reset_req,
    input logic alt_mode_req
);
    // R2
    rx_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R5
    hw_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        hw_reset_req |=> !hw_reset_req);

    // R5
    hw_not_driving_chk: assert property (@(posedge clk) disable iff (rst)
        hw_reset_req |-> !dio_oe && !tx_taken);

    // R8
    oe_inside_frame_chk: assert property (@(posedge clk) disable iff (rst)
        dio_oe |-> !$past(cs_s));

    // R7
    taken_after_drive_chk: assert property (@(posedge clk) disable iff (rst)
        tx_taken |-> $past(dio_oe));

    // R9
    alt_inside_frame_chk: assert property (@(posedge clk) disable iff (rst)
        alt_mode_req |-> !$past(cs_s));
endmodule

bind cs_byte_port csp_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_s         (cs_s),
    .dio_oe       (dio_oe),
    .tx_taken     (tx_taken),
    .rx_valid     (rx_valid),
    .hw_reset_req (hw_reset_req),
    .alt_mode_req (alt_mode_req)
);

// File: tb/tb_cs_byte_port.sv
module tb_cs_byte_port;
    localparam int CLK_P = 10;
    localparam int HALF  = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sclk = 1'b1, fsync = 1'b0, dio_in = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_valid = 1'b0;
    logic       dio_out, dio_oe, tx_taken, rx_valid, hw_reset_req, alt_mode_req;
    logic [7:0] rx_byte;

    int checks = 0, fails = 0;
    int n_rx = 0, n_hw = 0, n_tk = 0;
    logic [7:0] last_rx = '0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    cs_byte_port dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .fsync(fsync),
        .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_taken(tx_taken),
        .rx_byte(rx_byte), .rx_valid(rx_valid),
        .hw_reset_req(hw_reset_req), .alt_mode_req(alt_mode_req)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin n_rx++; last_rx = rx_byte; end
            if (hw_reset_req) n_hw++;
            if (tx_taken) n_tk++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_byte(input int n);
        return (n >= 8) && (n <= 15);
    endfunction

    // bits[n-1] is sent first; rd collects dio_out seen before each rise
    task automatic frame(input int n, input logic [23:0] bits,
                         output logic [23:0] rd, output logic first_bit,
                         output logic first_oe);
        rd = '0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        first_bit = dio_out;
        first_oe  = dio_oe;
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            dio_in = bits[n-1-i];
            repeat (HALF) @(negedge clk);
            rd = {rd[22:0], dio_out};
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic run_frame(input int n, input logic [23:0] bits, input string req);
        int rx0, hw0, tk0;
        logic [23:0] rd;
        logic fb, foe;
        logic pend;
        logic [7:0] txb;
        rx0 = n_rx; hw0 = n_hw; tk0 = n_tk;
        pend = tx_valid; txb = tx_byte;
        frame(n, bits, rd, fb, foe);
        chk((n_rx - rx0) == (is_byte(n) ? 1 : 0), req, n_rx - rx0, is_byte(n) ? 1 : 0);
        if (is_byte(n))
            chk(last_rx == bits[7:0], req, last_rx, bits[7:0]);
        chk((n_hw - hw0) == ((n >= 16) ? 1 : 0), req, n_hw - hw0, (n >= 16) ? 1 : 0);
        chk((n_tk - tk0) == ((pend && is_byte(n)) ? 1 : 0), req, n_tk - tk0,
            (pend && is_byte(n)) ? 1 : 0);
        // R7 first bit before any clock edge, R8 no drive without a pending byte
        chk(foe == pend, "R7/R8 oe at frame start", foe, pend);
        if (pend) begin
            chk(fb == txb[7], "R7 first bit", fb, txb[7]);
            if (n >= 8)
                chk(rd[n-1 -: 8] == txb, "R7 read bits", rd[n-1 -: 8], txb);
        end
        chk(!dio_oe, "R8 oe after frame", dio_oe, 0);
        if (n_tk != tk0) tx_valid = 1'b0;
    endtask

    task automatic fs_pulses(input int k);
        for (int i = 0; i < k; i++) begin
            fsync = 1'b1; repeat (10) @(negedge clk);
            fsync = 1'b0; repeat (10) @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!rx_valid && !hw_reset_req && !tx_taken && !alt_mode_req && !dio_oe,
            "R1 reset outputs", {rx_valid, hw_reset_req, tx_taken, alt_mode_req, dio_oe}, 0);

        // R2 exact byte
        run_frame(8, 24'h0000A5, "R2 eight edges");
        // R3 short frame with pending read: byte must survive
        tx_byte = 8'hC3; tx_valid = 1'b1;
        run_frame(5, 24'h00001F, "R3 short frame");
        chk(tx_valid == 1'b1, "R3 still pending", tx_valid, 1);
        chk(last_rx == 8'hA5, "R3 rx unchanged", last_rx, 8'hA5);
        run_frame(8, 24'h00003C, "R7 read after short");
        // R4 mid-length keeps last eight
        run_frame(12, 24'h000F96, "R4 twelve edges");
        run_frame(15, 24'h007E01, "R4 fifteen edges");
        // R5 overlong
        tx_byte = 8'h81; tx_valid = 1'b1;
        run_frame(16, 24'h00FFFF, "R5 sixteen edges");
        run_frame(20, 24'h0ABCDE, "R5 twenty edges");
        run_frame(8, 24'h000012, "R7 after long");

        // R6 clock activity with select high
        begin
            int rx0, hw0, tk0;
            rx0 = n_rx; hw0 = n_hw; tk0 = n_tk;
            tx_valid = 1'b1; tx_byte = 8'h5A;
            for (int i = 0; i < 20; i++) begin
                sclk = ~sclk; dio_in = ~dio_in; repeat (3) @(negedge clk);
            end
            sclk = 1'b0; repeat (40) @(negedge clk);
            sclk = 1'b1; repeat (40) @(negedge clk);
            chk(n_rx == rx0 && n_hw == hw0 && n_tk == tk0 && !dio_oe,
                "R6 idle activity", n_rx - rx0 + n_hw - hw0 + n_tk - tk0, 0);
            run_frame(8, 24'h0000E7, "R6 byte after idle");
        end

        // R9 static clock across frame-sync
        cs_n = 1'b0; repeat (HALF) @(negedge clk);
        fs_pulses(1);
        chk(!alt_mode_req, "R9 one period", alt_mode_req, 0);
        fs_pulses(2);
        chk(alt_mode_req, "R9 alt raised", alt_mode_req, 1);
        cs_n = 1'b1; repeat (10) @(negedge clk);
        chk(!alt_mode_req, "R9 alt cleared", alt_mode_req, 0);
        // R10 clock edge blocks the request
        cs_n = 1'b0; repeat (HALF) @(negedge clk);
        sclk = 1'b0; repeat (HALF) @(negedge clk);
        sclk = 1'b1; repeat (HALF) @(negedge clk);
        fs_pulses(4);
        chk(!alt_mode_req, "R10 blocked by edge", alt_mode_req, 0);
        cs_n = 1'b1; repeat (10) @(negedge clk);

        // random frames against the length rules
        for (int t = 0; t < 40; t++) begin
            int n;
            logic [23:0] b;
            n = $urandom_range(0, 20);
            b = 24'($urandom);
            if (!tx_valid && ($urandom % 2 == 1)) begin
                tx_byte = 8'($urandom); tx_valid = 1'b1;
            end
            run_frame(n, b, is_byte(n) ? "R4 random" : (n >= 16 ? "R5 random" : "R3 random"));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule